// File: doc/BRIEF.md
# Indexed I2C Configuration Register Target

This block is an I2C target that gives the rest of the chip a small bank of byte-wide configuration registers. A host on the two-wire bus programs the bank with indexed block writes: it names a starting register, states how many data bytes follow, then streams them. It reads the bank back with indexed block reads, in which the target first reports a byte count taken from a programmable count register and then streams register contents. The register index advances by one after every data byte in either direction and wraps at the end of the bank.

SCL and SDA arrive already synchronized to the system clock. The block samples them every clock, finds start, repeated start and stop conditions and SCL edges, and drives SDA only through an open-drain enable (`sda_oe` high pulls the line low). Every register is visible at all times on a flat parallel bus for the surrounding logic. SCL must stay in each phase for at least two system clocks.

Top module: `i2c_cfg_target`

## Requirements
- R1: The target answers the 7-bit address 0x69, so it acknowledges the address bytes 0xD2 (write) and 0xD3 (read). Any other address is not acknowledged, and every byte after it is ignored until the next start.
- R2: A write carries, after the address, an index byte N and a count byte X, both acknowledged. The next X data bytes are acknowledged and stored in registers N, N+1, and so on.
- R3: A data byte that arrives after X data bytes have been accepted is not acknowledged and is not stored. A count of 0 accepts no data byte.
- R4: A read is address 0xD2, index N, repeated start, address 0xD3. The target then sends the value of register 6 as a count byte, followed by register N, N+1, and so on, each byte MSB first.
- R5: When the host does not acknowledge a byte it reads, the target sends no further byte and leaves SDA released.
- R6: After reset, register 6 holds 6, register 7 holds 0x2A (revision 2 in bits 7:4, vendor 0xA in bits 3:0), all other registers hold 0, and SDA is released.
- R7: Register 7 is read-only and register 5 is reserved and always reads 0. Data bytes aimed at either are acknowledged, consume one count and advance the index, but change nothing.
- R8: The index moves up by one after every data byte written or read and wraps from 15 to 0. The index byte is taken modulo 16.
- R9: A stop condition at any point returns the target to idle with SDA released. Registers already written keep their values.
- R10: A start or repeated start in the middle of a byte drops the partial byte and restarts address reception, so a complete transfer that follows it works normally.
- R11: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level (the wired-AND of all drivers) |
| sda_oe | output | 1 | Open-drain enable, 1 pulls SDA low |
| cfg_regs | output | 128 | All registers, register r at bits 8r+7:8r |

## Verification
On every cycle the assertions check that SDA is released whenever the target is idle, that the SDA drive never changes while SCL is high, that a stop always leads to idle, that a start always restarts address reception, that a data byte beyond the count produces neither an acknowledge nor a write, and that each write lands in its register. Only the bench's scenarios can show that the right bytes come back in the right order: the count byte ahead of the data, MSB-first shifting, index wrap and modulo, the read-only and reserved registers staying unchanged, the rejection of a foreign address, and recovery after an aborted byte or an early stop. A behavioural register model in the bench is compared against the parallel register bus on every clock while the bus is idle.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } bus_st_e;

  typedef enum logic [1:0] {
    FLD_ADDR,
    FLD_INDEX,
    FLD_COUNT,
    FLD_DATA
  } rx_fld_e;

endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int             NUM_REGS = 16,
  parameter int             DW       = 8,
  parameter int             CNT_IDX  = 6,
  parameter logic [DW-1:0]  CNT_RST  = 8'd6,
  parameter int             ID_IDX   = 7,
  parameter logic [DW-1:0]  ID_VAL   = 8'h2A,
  parameter int             RSV_IDX  = 5,
  localparam int            AW       = $clog2(NUM_REGS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [DW-1:0]          wdata,
  input  logic [AW-1:0]          raddr,
  output logic [DW-1:0]          rdata,
  output logic [NUM_REGS*DW-1:0] flat
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g == ID_IDX) begin : g_id
      assign flat[g*DW +: DW] = ID_VAL;
    end else if (g == RSV_IDX) begin : g_rsv
      assign flat[g*DW +: DW] = '0;
    end else begin : g_rw
      localparam logic [DW-1:0] RV = (g == CNT_IDX) ? CNT_RST : '0;
      logic [DW-1:0] q;

      always_ff @(posedge clk) begin
        if (rst) q <= RV;
        else if (we && waddr == AW'(g)) q <= wdata;
      end

      assign flat[g*DW +: DW] = q;

      AST_WR_LANDS: assert property (@(posedge clk) disable iff (rst)
        (we && waddr == AW'(g)) |=> q == $past(wdata)); // R2
    end
  end

  assign rdata = flat[int'(raddr)*DW +: DW];

endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NUM_REGS = 16,
  parameter int         CNT_IDX  = 6,
  parameter logic [7:0] CNT_RST  = 8'd6,
  parameter int         ID_IDX   = 7,
  parameter logic [7:0] ID_VAL   = 8'h2A,
  parameter int         RSV_IDX  = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] cfg_regs
);
  import i2c_cfg_pkg::*;

  localparam int AW = $clog2(NUM_REGS);

  logic          scl_rise, scl_fall, start_det, stop_det;
  bus_st_e       st;
  rx_fld_e       fld;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg;
  logic [AW-1:0] idx;
  logic [7:0]    remain;
  logic          rd_mode;
  logic          host_nack;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic [7:0]    rd_data;
  logic [7:0]    count_val;
  logic [AW-1:0] idx_inc;

  i2c_bus_cond u_cond (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  cfg_reg_bank #(
    .NUM_REGS (NUM_REGS),
    .DW       (8),
    .CNT_IDX  (CNT_IDX),
    .CNT_RST  (CNT_RST),
    .ID_IDX   (ID_IDX),
    .ID_VAL   (ID_VAL),
    .RSV_IDX  (RSV_IDX)
  ) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (idx),
    .rdata (rd_data),
    .flat  (cfg_regs)
  );

  assign count_val = cfg_regs[CNT_IDX*8 +: 8];
  assign idx_inc   = (idx == AW'(NUM_REGS-1)) ? '0 : idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      fld       <= FLD_ADDR;
      bitcnt    <= '0;
      shreg     <= '0;
      idx       <= '0;
      remain    <= '0;
      rd_mode   <= 1'b0;
      host_nack <= 1'b0;
      sda_oe    <= 1'b0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st     <= ST_RX;
        fld    <= FLD_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_i};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              case (fld)
                FLD_ADDR: begin
                  if (shreg[7:1] == DEV_ADDR) begin
                    rd_mode <= shreg[0];
                    sda_oe  <= 1'b1;
                    st      <= ST_RX_ACK;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                FLD_INDEX: begin
                  idx    <= AW'(32'(shreg) % NUM_REGS);
                  sda_oe <= 1'b1;
                  st     <= ST_RX_ACK;
                end
                FLD_COUNT: begin
                  remain <= shreg;
                  sda_oe <= 1'b1;
                  st     <= ST_RX_ACK;
                end
                default: begin
                  if (remain != 8'd0) begin
                    wr_en   <= 1'b1;
                    wr_addr <= idx;
                    wr_data <= shreg;
                    idx     <= idx_inc;
                    remain  <= remain - 8'd1;
                    sda_oe  <= 1'b1;
                    st      <= ST_RX_ACK;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              if (fld == FLD_ADDR && rd_mode) begin
                shreg  <= count_val;
                sda_oe <= ~count_val[7];
                bitcnt <= '0;
                st     <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_RX;
                case (fld)
                  FLD_ADDR:  fld <= FLD_INDEX;
                  FLD_INDEX: fld <= FLD_COUNT;
                  default:   fld <= FLD_DATA;
                endcase
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0;
                st     <= ST_TX_ACK;
              end else begin
                sda_oe <= ~shreg[6];
                shreg  <= {shreg[6:0], 1'b0};
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              host_nack <= sda_i;
            end else if (scl_fall) begin
              if (host_nack) begin
                st <= ST_IDLE;
              end else begin
                shreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                idx    <= idx_inc;
                bitcnt <= '0;
                st     <= ST_TX;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !sda_oe); // R9

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i); // R11

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (st == ST_IDLE)); // R9

  AST_START_ADDR: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (st == ST_RX && fld == FLD_ADDR && bitcnt == 4'd0)); // R10

  AST_NO_OVERCOUNT: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RX && fld == FLD_DATA && scl_fall && bitcnt == 4'd8 &&
     remain == 8'd0 && !start_det && !stop_det) |=> (!sda_oe && !wr_en)); // R3

endmodule

// File: tb/i2c_cfg_target_bench.sv
module i2c_cfg_target_bench;

  localparam int CLK_PERIOD = 10;
  localparam int H          = 4;
  localparam int NREG       = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            scl = 1'b1;
  logic            sda_host = 1'b1;
  logic            sda_oe;
  logic            sda_line;
  logic [NREG*8-1:0] cfg_regs;

  int n_chk = 0;
  int n_fail = 0;
  int n_r11_viol = 0;
  bit cmp_en = 1'b0;
  logic [7:0] model [NREG];
  logic [7:0] txq [$];

  assign sda_line = sda_host & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cfg_target u_i2c_cfg_target (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl),
    .sda_i    (sda_line),
    .sda_oe   (sda_oe),
    .cfg_regs (cfg_regs)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit writable(input int r);
    return (r != 5) && (r != 7);
  endfunction

  // Reference model compared to the parallel bus on every idle clock
  always @(negedge clk) begin
    if (cmp_en) begin
      for (int r = 0; r < NREG; r++)
        check(cfg_regs[r*8 +: 8] == model[r], "R2/R7 register bus vs model",
              int'(cfg_regs[r*8 +: 8]), int'(model[r]));
    end
  end

  // R11 monitor: SDA drive must not move while SCL stays high
  logic scl_d = 1'b1;
  logic oe_d = 1'b0;
  always @(negedge clk) begin
    if (!rst && scl && scl_d && (sda_oe != oe_d)) n_r11_viol++;
    scl_d = scl;
    oe_d  = sda_oe;
  end

  task automatic bus_start();
    sda_host = 1'b1; tick(H);
    scl = 1'b1;      tick(H);
    sda_host = 1'b0; tick(H);
    scl = 1'b0;
  endtask

  task automatic bus_stop();
    sda_host = 1'b0; tick(H);
    scl = 1'b1;      tick(H);
    sda_host = 1'b1; tick(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sda_host = b[i]; tick(H);
      scl = 1'b1;      tick(H);
      scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_host = 1'b1; tick(H);
    scl = 1'b1;      tick(H/2);
    acked = !sda_line;
    tick(H/2);
    scl = 1'b0;
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b);
    sda_host = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H);
      scl = 1'b1; tick(H/2);
      b[i] = sda_line;
      tick(H/2);
      scl = 1'b0;
    end
    sda_host = ack ? 1'b0 : 1'b1; tick(H);
    scl = 1'b1; tick(H);
    scl = 1'b0;
    sda_host = 1'b1;
  endtask

  // Indexed block write of the bytes in txq; early_stop>0 stops after that many
  task automatic wr_xfer(input int n, input int cnt, input int early_stop);
    bit a;
    int ri;
    int rem;
    int sent;
    cmp_en = 1'b0;
    bus_start();
    send_byte(8'hD2, a);       check(a, "R1 write address ack", a, 1);
    send_byte(8'(n), a);       check(a, "R2 index ack", a, 1);
    send_byte(8'(cnt), a);     check(a, "R2 count ack", a, 1);
    ri = n % NREG;
    rem = cnt;
    sent = 0;
    foreach (txq[k]) begin
      bit exp;
      if (early_stop > 0 && sent == early_stop) break;
      exp = (rem > 0);
      send_byte(txq[k], a);
      sent++;
      check(a == exp, exp ? "R2 data ack" : "R3 over-count nack", a, exp);
      if (!exp) break;
      if (writable(ri)) model[ri] = txq[k];
      ri = (ri + 1) % NREG;
      rem--;
    end
    bus_stop();
    check(sda_oe == 1'b0, "R9 SDA released after stop", sda_oe, 0);
    tick(2);
    cmp_en = 1'b1;
    tick(4);
  endtask

  task automatic rd_xfer(input int n, input int nb);
    bit a;
    logic [7:0] b;
    int ri;
    cmp_en = 1'b0;
    bus_start();
    send_byte(8'hD2, a);   check(a, "R4 write address ack", a, 1);
    send_byte(8'(n), a);   check(a, "R4 index ack", a, 1);
    bus_start();
    send_byte(8'hD3, a);   check(a, "R1 read address ack", a, 1);
    recv_byte(1'b1, b);
    check(b == model[6], "R4 count byte first", b, model[6]);
    ri = n % NREG;
    for (int k = 0; k < nb; k++) begin
      recv_byte(k != nb - 1, b);
      check(b == model[ri], "R4/R8 read data", b, model[ri]);
      ri = (ri + 1) % NREG;
    end
    tick(H);
    check(sda_oe == 1'b0, "R5 released after host nack", sda_oe, 0);
    bus_stop();
    tick(2);
    cmp_en = 1'b1;
    tick(4);
  endtask

  initial begin
    bit a;
    for (int r = 0; r < NREG; r++) model[r] = 8'h00;
    model[6] = 8'd6;
    model[7] = 8'h2A;
    tick(4);
    rst = 1'b0;
    tick(2);

    // R6 reset state
    check(cfg_regs[6*8 +: 8] == 8'd6, "R6 count reset", cfg_regs[6*8 +: 8], 6);
    check(cfg_regs[7*8 +: 8] == 8'h2A, "R6 id reset", cfg_regs[7*8 +: 8], 8'h2A);
    check(cfg_regs[0 +: 8] == 8'h00, "R6 reg0 reset", cfg_regs[0 +: 8], 0);
    check(sda_oe == 1'b0, "R6 SDA released", sda_oe, 0);
    cmp_en = 1'b1;
    tick(4);

    // R2 plain write then R4 read-back
    txq = '{8'hA1, 8'h5B, 8'hC3, 8'h80};
    wr_xfer(0, 4, 0);
    rd_xfer(0, 4);

    // R1 foreign address: nack, following bytes ignored
    cmp_en = 1'b0;
    bus_start();
    send_byte(8'hA0, a); check(!a, "R1 foreign address nack", a, 0);
    send_byte(8'h02, a); check(!a, "R1 ignored after mismatch", a, 0);
    send_byte(8'hFF, a); check(!a, "R1 ignored after mismatch", a, 0);
    bus_stop();
    tick(2); cmp_en = 1'b1; tick(4);

    // R3 more data than count; zero count
    txq = '{8'h11, 8'h22, 8'h33};
    wr_xfer(8, 2, 0);
    txq = '{8'h44};
    wr_xfer(10, 0, 0);

    // R7 reserved / read-only / count register
    txq = '{8'h55, 8'h03, 8'h77};
    wr_xfer(5, 3, 0);
    rd_xfer(4, 4);

    // R8 wrap on write and on read, index modulo
    txq = '{8'hE1, 8'hF2, 8'h9A};
    wr_xfer(14, 3, 0);
    rd_xfer(14, 3);
    txq = '{8'h6C};
    wr_xfer(8'h12, 1, 0);
    rd_xfer(2, 1);

    // R9 stop in the middle of a write
    txq = '{8'hBE, 8'hEF, 8'h01, 8'h02};
    wr_xfer(11, 4, 1);
    rd_xfer(11, 2);

    // R10 start in the middle of the index byte
    cmp_en = 1'b0;
    bus_start();
    send_byte(8'hD2, a); check(a, "R10 address ack before abort", a, 1);
    send_bits(8'hF0, 3);
    txq = '{8'h3C, 8'hC3};
    wr_xfer(12, 2, 0);
    rd_xfer(12, 2);

    // R5 host nack on the very first data byte
    rd_xfer(0, 1);

    check(n_r11_viol == 0, "R11 SDA stable while SCL high", n_r11_viol, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule